// File: doc/BRIEF.md
# Gapped Serial Receive Byte Aligner

This block sits behind a serial receive line whose clock may be gapped or continuous. On every line clock edge it samples one data bit, a per-bit enable and a byte-sync marker. The enable's active level is set by a configuration input. A bit whose enable is inactive is dropped and does not count. In byte mode, a single sync pulse fixes the byte boundary. From then on the block builds bytes on its own, least significant bit first, and reports each byte with a one-cycle strobe. A later sync pulse that falls off the current boundary moves the boundary.

A mode input switches the block to a bit-stream mode for HDLC traffic. In that mode the sync marker is expected to be tied high and is ignored. Each accepted bit is forwarded on its own with a per-bit valid strobe, and no bytes are assembled.

Top module: `gap_byte_aligner`

## Requirements
- R1: A bit is accepted only on an edge where `data_en_i` equals `en_pol_i` (1 = enable active high, 0 = enable active low). A rejected bit changes neither the byte count nor any output.
- R2: Bits are packed least significant bit first. The first bit accepted together with sync lands in `byte_o[0]`, and the eighth accepted bit lands in `byte_o[7]`.
- R3: `byte_valid_o` is high for exactly one clock, following the edge that accepts the eighth bit of a byte.
- R4: Between reset and the first accepted sync pulse, `byte_valid_o` never rises and `aligned_o` stays low.
- R5: After one sync pulse, bytes keep coming every eight accepted bits with no further sync pulses.
- R6: An accepted sync pulse off the current boundary discards the partial byte and starts a new byte with that bit. When the pulse falls on the bit that would have completed a byte, no strobe is given for that edge.
- R7: A sync pulse on an edge whose enable is inactive has no effect.
- R8: `aligned_o` rises with the first completed byte. It stays high until reset or until bit-stream mode is selected.
- R9: With `hdlc_mode_i` high, sync is ignored. `bit_o` and `bit_valid_o` follow each accepted bit one clock later, `byte_valid_o` stays low and `aligned_o` is low. In byte mode `bit_valid_o` is low.
- R10: `byte_o` holds its value between strobes.
- R11: Asserting `rst_ni` low clears the bit count, the lock, the assembled data, all outputs and `aligned_o` at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line clock (may be gapped) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ser_data_i | input | 1 | Serial data bit |
| data_en_i | input | 1 | Per-bit data enable |
| en_pol_i | input | 1 | Enable active level: 1 high, 0 low |
| byte_sync_i | input | 1 | High on the first bit of a byte |
| hdlc_mode_i | input | 1 | 1 selects bit-stream mode, 0 byte mode |
| byte_o | output | BYTE_W | Assembled byte |
| byte_valid_o | output | 1 | One-cycle byte strobe |
| aligned_o | output | 1 | Byte boundary established |
| bit_o | output | 1 | Forwarded bit in bit-stream mode |
| bit_valid_o | output | 1 | Per-bit strobe in bit-stream mode |

## Verification
A sync pulse can land on the very edge that would otherwise complete a byte, so realignment and byte completion compete in one cycle. The bench locks the stream, accepts seven bits, and then sends the eighth accepted bit with sync high. It expects no strobe on that edge. It then expects the next strobe seven accepted bits later, carrying the collision bit in bit 0. A sync pulse held during a rejected bit is also placed where it would shift the boundary, and the result is judged by the value of the byte that follows.

// File: rtl/gba_pkg.sv
package gba_pkg;
  typedef enum logic {
    MODE_BYTE = 1'b0,
    MODE_BITS = 1'b1
  } rx_mode_e;

  localparam int unsigned DEF_BYTE_W = 8;
endpackage

// File: rtl/gba_qualify.sv
module gba_qualify
  import gba_pkg::*;
(
  input  logic     data_en_i,
  input  logic     en_pol_i,
  input  logic     byte_sync_i,
  input  rx_mode_e mode_i,
  output logic     acc_o,
  output logic     byte_acc_o,
  output logic     sync_hit_o
);
  always_comb begin
    acc_o      = (data_en_i == en_pol_i);
    byte_acc_o = acc_o && (mode_i == MODE_BYTE);
    // sync only counts on an accepted bit in byte mode
    sync_hit_o = byte_acc_o && byte_sync_i;
  end
endmodule

// File: rtl/gba_bit_count.sv
module gba_bit_count
  import gba_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  localparam int unsigned CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  rx_mode_e mode_i,
  input  logic     byte_acc_i,
  input  logic     sync_hit_i,
  output logic     shift_en_o,
  output logic     last_o
);
  localparam logic [CNT_W-1:0] LAST_POS = CNT_W'(BYTE_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             locked_q;

  always_comb begin
    shift_en_o = byte_acc_i && (locked_q || sync_hit_i);
    // realignment wins over completion
    last_o     = byte_acc_i && locked_q && !sync_hit_i && (cnt_q == LAST_POS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (mode_i == MODE_BITS) begin
      cnt_q    <= '0;
      locked_q <= 1'b0;
    end else if (sync_hit_i) begin
      cnt_q    <= CNT_W'(1 % BYTE_W);
      locked_q <= 1'b1;
    end else if (shift_en_o) begin
      cnt_q    <= last_o ? '0 : cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/gba_assemble.sv
module gba_assemble
  import gba_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_i,
  input  logic              shift_en_i,
  input  logic              last_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o
);
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] shreg_d;

  // lsb first: new bit enters at the top and walks down
  generate
    if (BYTE_W > 1) begin : g_wide
      assign shreg_d = {bit_i, shreg_q[BYTE_W-1:1]};
    end else begin : g_narrow
      assign shreg_d = bit_i;
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q      <= '0;
      byte_o       <= '0;
      byte_valid_o <= 1'b0;
    end else begin
      byte_valid_o <= last_i;
      if (shift_en_i) shreg_q <= shreg_d;
      if (last_i)     byte_o  <= shreg_d;
    end
  end
endmodule

// File: rtl/gap_byte_aligner.sv
module gap_byte_aligner
  import gba_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ser_data_i,
  input  logic              data_en_i,
  input  logic              en_pol_i,
  input  logic              byte_sync_i,
  input  logic              hdlc_mode_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              byte_valid_o,
  output logic              aligned_o,
  output logic              bit_o,
  output logic              bit_valid_o
);
  rx_mode_e mode;
  logic     acc, byte_acc, sync_hit, shift_en, last;

  assign mode = hdlc_mode_i ? MODE_BITS : MODE_BYTE;

  gba_qualify u_qual (
    .data_en_i   (data_en_i),
    .en_pol_i    (en_pol_i),
    .byte_sync_i (byte_sync_i),
    .mode_i      (mode),
    .acc_o       (acc),
    .byte_acc_o  (byte_acc),
    .sync_hit_o  (sync_hit)
  );

  gba_bit_count #(.BYTE_W(BYTE_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .byte_acc_i (byte_acc),
    .sync_hit_i (sync_hit),
    .shift_en_o (shift_en),
    .last_o     (last)
  );

  gba_assemble #(.BYTE_W(BYTE_W)) u_asm (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bit_i        (ser_data_i),
    .shift_en_i   (shift_en),
    .last_i       (last),
    .byte_o       (byte_o),
    .byte_valid_o (byte_valid_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      aligned_o   <= 1'b0;
      bit_o       <= 1'b0;
      bit_valid_o <= 1'b0;
    end else begin
      if (mode == MODE_BITS) aligned_o <= 1'b0;
      else if (last)         aligned_o <= 1'b1;
      bit_valid_o <= acc && (mode == MODE_BITS);
      if (acc && (mode == MODE_BITS)) bit_o <= ser_data_i;
    end
  end
endmodule

// File: rtl/gap_byte_aligner_chk.sv
module gap_byte_aligner_chk #(
  parameter int unsigned BYTE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              data_en_i,
  input logic              en_pol_i,
  input logic              hdlc_mode_i,
  input logic [BYTE_W-1:0] byte_o,
  input logic              byte_valid_o,
  input logic              aligned_o,
  input logic              bit_valid_o
);
  // R3
  strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o);

  // R1
  reject_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_en_i != en_pol_i) |=> (!byte_valid_o && !bit_valid_o));

  // R9
  bits_mode_no_byte_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hdlc_mode_i |=> (!byte_valid_o && !aligned_o));

  // R9
  byte_mode_no_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdlc_mode_i |=> !bit_valid_o);

  // R10
  byte_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o |-> $stable(byte_o));

  // R8
  aligned_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(aligned_o) |-> byte_valid_o);
endmodule

bind gap_byte_aligner gap_byte_aligner_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .data_en_i    (data_en_i),
  .en_pol_i     (en_pol_i),
  .hdlc_mode_i  (hdlc_mode_i),
  .byte_o       (byte_o),
  .byte_valid_o (byte_valid_o),
  .aligned_o    (aligned_o),
  .bit_valid_o  (bit_valid_o)
);

// File: tb/gap_byte_aligner_test.sv
module gap_byte_aligner_test;
  localparam int CLK_P = 10;
  localparam int NV    = 29;
  // {data, enable, sync, expect_valid, expect_byte}; enable polarity high
  localparam logic [11:0] VEC [NV] = '{
    {3'b111, 1'b0, 8'h00},  // sync, b0=1
    {3'b010, 1'b0, 8'h00},
    {3'b001, 1'b0, 8'h00},  // rejected bit with sync: R7
    {3'b110, 1'b0, 8'h00},
    {3'b010, 1'b0, 8'h00},
    {3'b010, 1'b0, 8'h00},
    {3'b110, 1'b0, 8'h00},
    {3'b010, 1'b0, 8'h00},
    {3'b110, 1'b1, 8'hA5},
    {3'b010, 1'b0, 8'h00},  // free-running byte, no sync: R5
    {3'b010, 1'b0, 8'h00},
    {3'b110, 1'b0, 8'h00},
    {3'b000, 1'b0, 8'h00},  // gap
    {3'b110, 1'b0, 8'h00},
    {3'b110, 1'b0, 8'h00},
    {3'b110, 1'b0, 8'h00},
    {3'b010, 1'b0, 8'h00},
    {3'b010, 1'b1, 8'h3C},
    {3'b110, 1'b0, 8'h00},  // partial, to be dropped: R6
    {3'b110, 1'b0, 8'h00},
    {3'b110, 1'b0, 8'h00},
    {3'b111, 1'b0, 8'h00},  // realign
    {3'b110, 1'b0, 8'h00},
    {3'b110, 1'b0, 8'h00},
    {3'b110, 1'b0, 8'h00},
    {3'b010, 1'b0, 8'h00},
    {3'b010, 1'b0, 8'h00},
    {3'b010, 1'b0, 8'h00},
    {3'b010, 1'b1, 8'h0F}
  };

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ser_data = 1'b0, data_en = 1'b0, en_pol = 1'b1, byte_sync = 1'b0, hdlc = 1'b0;
  logic [7:0] byte_o;
  logic       byte_valid, aligned, bit_o, bit_valid;
  int         checks = 0, errors = 0;
  logic [7:0] last_byte;

  gap_byte_aligner uut (
    .clk_i(clk), .rst_ni(rst_ni), .ser_data_i(ser_data), .data_en_i(data_en),
    .en_pol_i(en_pol), .byte_sync_i(byte_sync), .hdlc_mode_i(hdlc),
    .byte_o(byte_o), .byte_valid_o(byte_valid), .aligned_o(aligned),
    .bit_o(bit_o), .bit_valid_o(bit_valid)
  );

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic en, input logic s);
    @(negedge clk);
    ser_data = d; data_en = en; byte_sync = s;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    // R11 reset state
    #1;
    check("R11 byte", byte_o, 8'h00);
    check("R11 flags", {4'b0, byte_valid, aligned, bit_o, bit_valid}, 8'h00);
    do_reset();

    // R4: no strobes before sync
    for (int i = 0; i < 10; i++) begin
      step(1'b1, 1'b1, 1'b0);
      check("R4 valid", {7'b0, byte_valid}, 8'h00);
    end
    check("R4 aligned", {7'b0, aligned}, 8'h00);

    // vector walk: R2 R3 R5 R6 R7 R8 R10
    last_byte = 8'h00;
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][11], VEC[i][10], VEC[i][9]);
      check("R3 strobe", {7'b0, byte_valid}, {7'b0, VEC[i][8]});
      if (VEC[i][8]) begin
        last_byte = VEC[i][7:0];
        check("R2 byte", byte_o, last_byte);
        check("R8 aligned", {7'b0, aligned}, 8'h01);
      end else begin
        check("R10 hold", byte_o, last_byte);
      end
    end
    step(1'b0, 1'b1, 1'b0);
    check("R3 one cycle", {7'b0, byte_valid}, 8'h00);

    // R9 bit-stream mode, sync held high; also clears aligned
    hdlc = 1'b1;
    step(1'b1, 1'b1, 1'b1);
    check("R9 bit", {6'b0, bit_valid, bit_o}, 8'h03);
    check("R9 aligned", {7'b0, aligned}, 8'h00);
    step(1'b1, 1'b0, 1'b1);
    check("R9 gap", {7'b0, bit_valid}, 8'h00);
    for (int i = 0; i < 10; i++) begin
      step(1'(i % 2), 1'b1, 1'b1);
      check("R9 stream", {5'b0, byte_valid, bit_valid, bit_o}, {6'b0, 1'b1, 1'(i % 2)});
    end
    hdlc = 1'b0;

    // R1 active-low enable, gap with enable high
    en_pol = 1'b0;
    do_reset();
    step(1'b1, 1'b0, 1'b1);
    for (int i = 1; i < 8; i++) begin
      if (i == 4) step(1'b1, 1'b1, 1'b0);
      step(i == 7, 1'b0, 1'b0);
      if (i < 7) check("R1 no strobe", {7'b0, byte_valid}, 8'h00);
    end
    check("R1 polarity", {7'b0, byte_valid}, 8'h01);
    check("R1 byte", byte_o, 8'h81);
    en_pol = 1'b1;

    // R6 sync on the completing bit: collision
    do_reset();
    step(1'b1, 1'b1, 1'b1);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b1, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    check("R6 collision", {7'b0, byte_valid}, 8'h00);
    for (int i = 0; i < 7; i++) begin
      step(1'b1, 1'b1, 1'b0);
      if (i < 6) check("R6 wait", {7'b0, byte_valid}, 8'h00);
    end
    check("R6 strobe", {7'b0, byte_valid}, 8'h01);
    check("R6 byte", byte_o, 8'hFE);

    // R11 reset mid-byte drops lock
    step(1'b1, 1'b1, 1'b0);
    do_reset();
    check("R11 mid", {7'b0, aligned}, 8'h00);
    check("R11 mid byte", byte_o, 8'h00);
    for (int i = 0; i < 9; i++) begin
      step(1'b1, 1'b1, 1'b0);
      check("R11 unlocked", {7'b0, byte_valid}, 8'h00);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule